// File: doc/BRIEF.md
# Shared Serial Flash Pin Arbiter

This block lets two agents share one set of serial flash pins: the user design's own flash controller and an external loader agent that takes the pins over from time to time. The shared pins are the serial clock, an active-low chip select and four data lines. Each data line has its own output enable, because the lines are bidirectional at the pad. The loader raises a request that is asynchronous to the flash clock. The block brings that request into the flash clock domain through a flop synchronizer. It waits until the user controller is between chip-select transactions, and only then raises the grant and switches the pins over.

While the loader owns the pins, the user controller sees a busy flag and its chip select is kept away from the pad. The grant stays high for as long as the request does. Once the request falls, the grant drops and the pins are parked for a fixed number of cycles: chip select high, clock low, no data line driven. After that the user controller gets the pins back. An active-low enable from the loader side can hold the loader's drive off while it holds the grant. In that case the pins stay parked.

Top module: `shared_flash_arbiter`

## Requirements
- R1: After reset the grant and the busy flag are low, and every pad output follows the user controller's signals.
- R2: Once the grant is high it stays high for as long as the synchronized request is high. It falls exactly three clock edges after the asynchronous request falls (two synchronizer edges and one state edge).
- R3: The request passes through a two-flop synchronizer. With the user chip select high, the grant rises on the fourth clock edge after the request rises.
- R4: The grant never rises while the user chip select is low. It rises on the first edge that follows a full cycle of user chip select high after the synchronized request is seen.
- R5: While the grant is high and the loader is enabled, the pad clock, chip select, data outputs and per-line output enables come from the loader, and busy is high. The user chip select does not reach the pad.
- R6: While the loader holds the grant with its active-low enable high, the pad chip select is high, the pad clock is low and all four pad output enables are 0.
- R7: After the grant falls, for two cycles the pad chip select is high, the pad clock is low, all pad output enables are 0, and busy stays high. Then the user controller's signals reach the pads and busy falls.
- R8: A request that is withdrawn before the grant is issued leaves the grant low and the pins with the user controller.
- R9: Each of the four pad output enables and data outputs follows bit for bit the owning agent's enable and data for that line. An enable of 1 drives the line and 0 leaves it as an input.
- R10: The user's data input copies the pad data input only while the user owns the pins and reads 0 otherwise. The loader's data input copies the pad data input only while the loader holds the grant and is enabled, and reads 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Flash-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ldr_req_async | input | 1 | Loader access request, asynchronous |
| ldr_grant | output | 1 | Access grant to the loader, registered |
| ldr_en_n | input | 1 | Active-low enable of the loader's pin drive |
| ldr_sclk | input | 1 | Loader serial clock |
| ldr_cs_n | input | 1 | Loader chip select, active low |
| ldr_dout | input | 4 | Loader data toward the pads |
| ldr_doe | input | 4 | Loader per-line output enables |
| ldr_din | output | 4 | Pad data returned to the loader |
| usr_sclk | input | 1 | User serial clock |
| usr_cs_n | input | 1 | User chip select, active low |
| usr_dout | input | 4 | User data toward the pads |
| usr_doe | input | 4 | User per-line output enables |
| usr_din | output | 4 | Pad data returned to the user |
| usr_busy | output | 1 | Pins are held by the loader or parked |
| pad_sclk | output | 1 | Serial clock to the pad |
| pad_cs_n | output | 1 | Chip select to the pad |
| pad_dout | output | 4 | Data to the pad drivers |
| pad_doe | output | 4 | Output enables of the pad drivers |
| pad_din | input | 4 | Data sampled from the pads |

## Verification
The hardest case to reach is a request that arrives while the user controller is part way through a long chip-select-low transaction. The grant must hold off for as many cycles as the transaction lasts and then rise exactly one edge after chip select goes high. The stimulus raises the request while user chip select is low and keeps it low for eight cycles, checking every cycle that the grant stays low. It then releases chip select and expects the grant on the following cycle. A one-cycle request pulse is also used: it reaches the wait state but is withdrawn before any grant.

// File: rtl/flash_arb_pkg.sv
package flash_arb_pkg;

  typedef enum logic [1:0] {
    ARB_USER = 2'b00,
    ARB_WAIT = 2'b01,
    ARB_LDR  = 2'b10,
    ARB_BACK = 2'b11
  } arb_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/flash_arb_sync.sv
module flash_arb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/flash_arb_ctrl.sv
module flash_arb_ctrl
  import flash_arb_pkg::*;
#(
  parameter int unsigned IDLE_CYCLES = 1,
  parameter int unsigned HOLD_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_sync,
  input  logic usr_cs_n,
  output logic grant,
  output logic sel_ldr,
  output logic park,
  output logic busy
);

  localparam int unsigned CNT_MAX = max2(IDLE_CYCLES, HOLD_CYCLES);
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] IDLE_LAST = CNT_W'(IDLE_CYCLES - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYCLES - 1);

  arb_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             grant_q, grant_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      ARB_USER: begin
        if (req_sync) begin
          state_d = ARB_WAIT;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      ARB_WAIT: begin
        cnt_en = 1'b1;
        if (!req_sync) begin
          state_d = ARB_USER;
          cnt_d   = '0;
        end else if (usr_cs_n) begin
          if (cnt_q == IDLE_LAST) begin
            state_d = ARB_LDR;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end else begin
          cnt_d = '0;
        end
      end
      ARB_LDR: begin
        if (!req_sync) begin
          state_d = ARB_BACK;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      ARB_BACK: begin
        cnt_en = 1'b1;
        if (cnt_q == HOLD_LAST) begin
          state_d = ARB_USER;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = ARB_USER;
        cnt_d   = '0;
        cnt_en  = 1'b1;
      end
    endcase
    grant_d = (state_d == ARB_LDR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_USER;
      grant_q <= 1'b0;
    end else begin
      state_q <= state_d;
      grant_q <= grant_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign grant   = grant_q;
  assign sel_ldr = (state_q == ARB_LDR);
  assign park    = (state_q == ARB_BACK);
  assign busy    = sel_ldr | park;

  // R2: grant held while the synchronized request stays high
  assert_grant_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && req_sync) |=> grant);

  // R4: grant rises only after a cycle with user chip select high
  assert_no_rise_in_txn_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant) |-> $past(usr_cs_n));

  // R8: no grant ever rises without a synchronized request behind it
  assert_rise_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant) |-> $past(req_sync));

endmodule

// File: rtl/flash_arb_pinmux.sv
module flash_arb_pinmux #(
  parameter int unsigned LINES = 4
) (
  input  logic             sel_ldr,
  input  logic             park,
  input  logic             ldr_en_n,
  input  logic             ldr_sclk,
  input  logic             ldr_cs_n,
  input  logic [LINES-1:0] ldr_dout,
  input  logic [LINES-1:0] ldr_doe,
  output logic [LINES-1:0] ldr_din,
  input  logic             usr_sclk,
  input  logic             usr_cs_n,
  input  logic [LINES-1:0] usr_dout,
  input  logic [LINES-1:0] usr_doe,
  output logic [LINES-1:0] usr_din,
  output logic             pad_sclk,
  output logic             pad_cs_n,
  output logic [LINES-1:0] pad_dout,
  output logic [LINES-1:0] pad_doe,
  input  logic [LINES-1:0] pad_din
);

  logic ldr_live;
  logic parked;
  logic usr_live;

  assign ldr_live = sel_ldr & ~ldr_en_n;
  assign parked   = park | (sel_ldr & ldr_en_n);
  assign usr_live = ~sel_ldr & ~park;

  always_comb begin
    if (ldr_live) begin
      pad_sclk = ldr_sclk;
      pad_cs_n = ldr_cs_n;
    end else if (parked) begin
      pad_sclk = 1'b0;
      pad_cs_n = 1'b1;
    end else begin
      pad_sclk = usr_sclk;
      pad_cs_n = usr_cs_n;
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign pad_doe[i]  = ldr_live ? ldr_doe[i]  : (usr_live ? usr_doe[i]  : 1'b0);
    assign pad_dout[i] = ldr_live ? ldr_dout[i] : (usr_live ? usr_dout[i] : 1'b0);
    assign usr_din[i]  = usr_live & pad_din[i];
    assign ldr_din[i]  = ldr_live & pad_din[i];
  end

endmodule

// File: rtl/shared_flash_arbiter.sv
module shared_flash_arbiter #(
  parameter int unsigned LINES       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned IDLE_CYCLES = 1,
  parameter int unsigned HOLD_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ldr_req_async,
  output logic             ldr_grant,
  input  logic             ldr_en_n,
  input  logic             ldr_sclk,
  input  logic             ldr_cs_n,
  input  logic [LINES-1:0] ldr_dout,
  input  logic [LINES-1:0] ldr_doe,
  output logic [LINES-1:0] ldr_din,
  input  logic             usr_sclk,
  input  logic             usr_cs_n,
  input  logic [LINES-1:0] usr_dout,
  input  logic [LINES-1:0] usr_doe,
  output logic [LINES-1:0] usr_din,
  output logic             usr_busy,
  output logic             pad_sclk,
  output logic             pad_cs_n,
  output logic [LINES-1:0] pad_dout,
  output logic [LINES-1:0] pad_doe,
  input  logic [LINES-1:0] pad_din
);

  logic req_sync;
  logic sel_ldr;
  logic park;

  flash_arb_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (ldr_req_async),
    .q_sync  (req_sync)
  );

  flash_arb_ctrl #(
    .IDLE_CYCLES (IDLE_CYCLES),
    .HOLD_CYCLES (HOLD_CYCLES)
  ) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_sync (req_sync),
    .usr_cs_n (usr_cs_n),
    .grant    (ldr_grant),
    .sel_ldr  (sel_ldr),
    .park     (park),
    .busy     (usr_busy)
  );

  flash_arb_pinmux #(.LINES(LINES)) i_mux (
    .sel_ldr  (sel_ldr),
    .park     (park),
    .ldr_en_n (ldr_en_n),
    .ldr_sclk (ldr_sclk),
    .ldr_cs_n (ldr_cs_n),
    .ldr_dout (ldr_dout),
    .ldr_doe  (ldr_doe),
    .ldr_din  (ldr_din),
    .usr_sclk (usr_sclk),
    .usr_cs_n (usr_cs_n),
    .usr_dout (usr_dout),
    .usr_doe  (usr_doe),
    .usr_din  (usr_din),
    .pad_sclk (pad_sclk),
    .pad_cs_n (pad_cs_n),
    .pad_dout (pad_dout),
    .pad_doe  (pad_doe),
    .pad_din  (pad_din)
  );

  // R3: a synchronized request edge traces back to the raw request two edges earlier
  assert_sync_depth_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_sync) |-> $past(ldr_req_async, 2));

  // R5: a user transaction start never reaches the pad while the loader holds the pins and is gated off
  assert_user_cs_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (usr_busy && !usr_cs_n && ldr_en_n) |-> pad_cs_n);

  // R6: a disabled loader leaves the pads undriven
  assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ldr_grant && ldr_en_n) |-> (pad_cs_n && (pad_doe == '0)));

  // R7: two parked cycles follow the grant falling
  assert_handback_park_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ldr_grant) |-> (pad_cs_n && !pad_sclk && (pad_doe == '0) && usr_busy)
      ##1 (pad_cs_n && !pad_sclk && (pad_doe == '0) && usr_busy));

endmodule

// File: tb/test_shared_flash_arbiter.sv
module test_shared_flash_arbiter;

  typedef enum logic [1:0] {M_USR, M_LDR, M_PARK} own_e;

  typedef struct {
    string      tag;
    logic       grant;
    logic       busy;
    logic       sclk;
    logic       cs_n;
    logic [3:0] doe;
    logic [3:0] dout;
    logic [3:0] udin;
    logic [3:0] ldin;
  } exp_t;

  typedef struct {
    logic       rst_n;
    logic       req;
    logic       en_n;
    logic       l_sclk, l_cs_n;
    logic [3:0] l_dout, l_doe;
    logic       u_sclk, u_cs_n;
    logic [3:0] u_dout, u_doe;
    logic [3:0] p_din;
  } stim_t;

  logic clk;
  logic rst_n;
  logic ldr_req_async, ldr_grant, ldr_en_n, ldr_sclk, ldr_cs_n;
  logic [3:0] ldr_dout, ldr_doe, ldr_din;
  logic usr_sclk, usr_cs_n, usr_busy;
  logic [3:0] usr_dout, usr_doe, usr_din;
  logic pad_sclk, pad_cs_n;
  logic [3:0] pad_dout, pad_doe, pad_din;

  stim_t st;
  exp_t  sb_q[$];
  int    vectors = 0;
  int    errors  = 0;
  bit    done    = 0;

  shared_flash_arbiter i_shared_flash_arbiter (
    .clk(clk), .rst_n(rst_n),
    .ldr_req_async(ldr_req_async), .ldr_grant(ldr_grant), .ldr_en_n(ldr_en_n),
    .ldr_sclk(ldr_sclk), .ldr_cs_n(ldr_cs_n), .ldr_dout(ldr_dout), .ldr_doe(ldr_doe),
    .ldr_din(ldr_din),
    .usr_sclk(usr_sclk), .usr_cs_n(usr_cs_n), .usr_dout(usr_dout), .usr_doe(usr_doe),
    .usr_din(usr_din), .usr_busy(usr_busy),
    .pad_sclk(pad_sclk), .pad_cs_n(pad_cs_n), .pad_dout(pad_dout), .pad_doe(pad_doe),
    .pad_din(pad_din)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // driver: one cycle of stimulus plus the item the outputs must show
  task automatic step(input string tag, input own_e m, input logic g, input logic b);
    exp_t e;
    @(negedge clk);
    rst_n = st.rst_n; ldr_req_async = st.req; ldr_en_n = st.en_n;
    ldr_sclk = st.l_sclk; ldr_cs_n = st.l_cs_n; ldr_dout = st.l_dout; ldr_doe = st.l_doe;
    usr_sclk = st.u_sclk; usr_cs_n = st.u_cs_n; usr_dout = st.u_dout; usr_doe = st.u_doe;
    pad_din = st.p_din;
    e.tag = tag; e.grant = g; e.busy = b;
    e.udin = (m == M_USR) ? st.p_din : 4'h0;
    e.ldin = (m == M_LDR) ? st.p_din : 4'h0;
    case (m)
      M_USR: begin e.sclk = st.u_sclk; e.cs_n = st.u_cs_n; e.doe = st.u_doe; e.dout = st.u_dout; end
      M_LDR: begin e.sclk = st.l_sclk; e.cs_n = st.l_cs_n; e.doe = st.l_doe; e.dout = st.l_dout; end
      default: begin e.sclk = 1'b0; e.cs_n = 1'b1; e.doe = 4'h0; e.dout = 4'h0; end
    endcase
    sb_q.push_back(e);
  endtask

  // monitor: pops the expected item and compares, away from the clock edge
  always @(negedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      vectors++;
      if ({ldr_grant, usr_busy, pad_sclk, pad_cs_n, pad_doe, pad_dout, usr_din, ldr_din} !==
          {e.grant, e.busy, e.sclk, e.cs_n, e.doe, e.dout, e.udin, e.ldin}) begin
        errors++;
        $display("FAIL %s: got g=%b b=%b sclk=%b cs=%b doe=%h dout=%h udin=%h ldin=%h exp g=%b b=%b sclk=%b cs=%b doe=%h dout=%h udin=%h ldin=%h",
          e.tag, ldr_grant, usr_busy, pad_sclk, pad_cs_n, pad_doe, pad_dout, usr_din, ldr_din,
          e.grant, e.busy, e.sclk, e.cs_n, e.doe, e.dout, e.udin, e.ldin);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run, exp completion");
      finish_run();
    end
  end

  initial begin
    st = '{rst_n:1'b0, req:1'b0, en_n:1'b0, l_sclk:1'b0, l_cs_n:1'b1, l_dout:4'h0, l_doe:4'h0,
           u_sclk:1'b0, u_cs_n:1'b1, u_dout:4'h0, u_doe:4'h0, p_din:4'h0};
    rst_n = 1'b0; ldr_req_async = 1'b0; ldr_en_n = 1'b0; ldr_sclk = 1'b0; ldr_cs_n = 1'b1;
    ldr_dout = 4'h0; ldr_doe = 4'h0; usr_sclk = 1'b0; usr_cs_n = 1'b1; usr_dout = 4'h0;
    usr_doe = 4'h0; pad_din = 4'h0;

    // R1: reset state
    st.u_sclk = 1'b1; st.u_doe = 4'h5; st.u_dout = 4'hA; st.p_din = 4'h3;
    step("R1 reset", M_USR, 0, 0);
    step("R1 reset", M_USR, 0, 0);
    st.rst_n = 1'b1;
    step("R1 after reset", M_USR, 0, 0);

    // R9 / R10: user traffic, varied per-line enables and data
    st.u_cs_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      st.u_sclk = i[0]; st.u_doe = 4'(1 << i); st.u_dout = 4'(4'hF >> i); st.p_din = 4'(4'h9 ^ i);
      step("R9 R10 user lines", M_USR, 0, 0);
    end
    st.u_cs_n = 1'b1; st.u_sclk = 1'b0;
    step("R9 user idle", M_USR, 0, 0);

    // R3: request with user idle, grant on fourth edge
    st.req = 1'b1;
    for (int j = 0; j < 4; j++) step("R3 sync latency", M_USR, 0, 0);
    // R5 / R9 / R10: loader traffic while granted, user tries a transaction
    st.l_cs_n = 1'b0; st.u_cs_n = 1'b0; st.u_dout = 4'h7; st.u_doe = 4'hF;
    for (int j = 0; j < 5; j++) begin
      st.l_sclk = j[0]; st.l_doe = 4'(4'hC >> j[1:0]); st.l_dout = 4'(j * 3); st.p_din = 4'(j + 6);
      step("R5 R9 R10 loader owns", M_LDR, 1, 1);
    end
    st.u_cs_n = 1'b1;
    // R2: request falls, grant held for three more samples
    st.req = 1'b0;
    for (int j = 0; j < 3; j++) step("R2 grant hold", M_LDR, 1, 1);
    // R7: two parked cycles then user back
    st.u_cs_n = 1'b0;
    step("R7 park 1", M_PARK, 0, 1);
    step("R7 park 2", M_PARK, 0, 1);
    step("R7 user back", M_USR, 0, 0);
    st.u_cs_n = 1'b1;
    step("R7 user idle", M_USR, 0, 0);

    // R4: request during a long user transaction
    st.u_cs_n = 1'b0; st.req = 1'b1;
    for (int j = 0; j < 8; j++) begin
      st.u_sclk = j[0];
      step("R4 hold off in txn", M_USR, 0, 0);
    end
    st.u_cs_n = 1'b1; st.u_sclk = 1'b0;
    step("R4 idle cycle", M_USR, 0, 0);
    step("R4 grant after idle", M_LDR, 1, 1);
    // R6: loader disabled while holding the grant
    st.en_n = 1'b1; st.l_doe = 4'hF; st.l_cs_n = 1'b0; st.l_sclk = 1'b1; st.u_cs_n = 1'b0;
    step("R6 disabled", M_PARK, 1, 1);
    step("R6 disabled", M_PARK, 1, 1);
    st.en_n = 1'b0;
    step("R6 re-enabled", M_LDR, 1, 1);
    st.req = 1'b0;
    for (int j = 0; j < 3; j++) step("R2 grant hold", M_LDR, 1, 1);
    step("R7 park 1", M_PARK, 0, 1);
    step("R7 park 2", M_PARK, 0, 1);
    step("R7 user back", M_USR, 0, 0);

    // R8: one-cycle request pulse, withdrawn before any grant
    st.u_cs_n = 1'b1;
    step("R8 idle", M_USR, 0, 0);
    st.req = 1'b1;
    step("R8 pulse", M_USR, 0, 0);
    st.req = 1'b0;
    for (int j = 0; j < 8; j++) step("R8 no grant", M_USR, 0, 0);

    @(negedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule